// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets a host processor reach a bank of 64 registers, each 24 bits wide, through a four-wire serial port. Each transaction is one 32-bit frame, sent most significant bit first while the active-low select is held low. The first bit is a direction flag: 1 asks for a write and 0 asks for a read. Six address bits follow, then one bit that is ignored, then 24 data bits. The serial clock idles low. The host drives a data bit before the rising serial clock edge and reads the returned bit on that same rising edge. The block changes its serial output only on falling edges.

All logic runs on a single system clock. The three serial inputs pass through a synchroniser before use. The register bank lies outside the block and is reached through a plain port: address, write data, a one-cycle write strobe, and read data. On a write frame the strobe fires once, and only after all 32 bits have arrived with select still low. On a read frame the addressed word is fetched after the ignored bit. Its 24 bits are then shifted out during the data phase of the same frame.

Top module: `spi_regbus_slave`

## Requirements
- R1: After reset, `rf_we` is 0, `spi_miso` is 0 and `rf_addr` is 0.
- R2: In a frame, bit 31 (sent first) is the direction flag, bits 30..25 are the register address and bits 23..0 are the data. If the flag is 1, `rf_we` pulses high with `rf_addr` equal to the frame address and `rf_wdata` equal to the frame data, a few system clocks after the 32nd rising serial clock edge.
- R3: Bit 24 of the frame is ignored. Setting it to 1 changes neither the address nor the data written.
- R4: If the flag is 0, no write strobe occurs. The word on `rf_rdata` for the frame address is returned on `spi_miso`, most significant bit first. Each bit is valid at rising edges 9 through 32. `spi_miso` changes only after falling edges.
- R5: If select goes high before the 32nd rising edge, the frame is dropped and no write strobe occurs.
- R6: `spi_miso` is 0 whenever select is high. It also stays 0 for the whole of a write frame.
- R7: Rising edges after the 32nd in the same frame are ignored. They cause no second strobe and do not change the data written.
- R8: `rf_addr` takes the frame address after the 7th rising edge. It then holds that value, including while select is high, until the next frame reaches its 7th edge.
- R9: Each complete write frame produces exactly one `rf_we` pulse, one system clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low frame select from the host |
| spi_sck | input | 1 | Serial clock from the host, idles low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, registered |
| rf_addr | output | 6 | Register bank address |
| rf_wdata | output | 24 | Register bank write data |
| rf_we | output | 1 | Register bank write strobe, one clock wide |
| rf_rdata | input | 24 | Register bank read data for `rf_addr` |

## Verification
The embedded assertions are checked on every cycle. They cover:
- the single-cycle width of the write strobe;
- the limit on the bit counter;
- the address holding still between frames;
- the serial output being 0 while deselected, and changing only after a falling edge.

Other behaviour needs the bench's scenarios, checked at the pins against a behavioural model:
- frame decoding, so that the correct address and data reach the strobe;
- the returned read bits lining up with rising edges 9 to 32;
- aborted frames being dropped, and over-length frames leaving the write unchanged.

// File: rtl/spi_regbus_pkg.sv
package spi_regbus_pkg;
  localparam int ADDR_W_DEF = 6;
  localparam int DATA_W_DEF = 24;
  localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/spi_regbus_sync.sv
module spi_regbus_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[g] <= INIT;
        else     st[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= INIT;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/spi_regbus_rx.sv
module spi_regbus_rx #(
  parameter int AW = 6,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          sck_rise,
  input  logic          mosi,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata,
  output logic          rf_we,
  output logic          tx_load,
  output logic          tx_shift_ok
);
  localparam int FW     = AW + DW + 2;
  localparam int CW     = $clog2(FW + 1);
  localparam int HDR    = AW + 1;
  localparam int DSTART = AW + 2;

  logic [CW-1:0] cnt;
  logic [DW-2:0] sh;
  logic          wr_cmd, rd_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sh       <= '0;
      wr_cmd   <= 1'b0;
      rd_cmd   <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
      rf_we    <= 1'b0;
      tx_load  <= 1'b0;
    end else begin
      rf_we   <= 1'b0;
      tx_load <= 1'b0;
      if (!cs_act) begin
        cnt    <= '0;
        wr_cmd <= 1'b0;
        rd_cmd <= 1'b0;
      end else if (sck_rise && cnt < CW'(FW)) begin
        cnt <= cnt + 1'b1;
        sh  <= {sh[DW-3:0], mosi};
        if (cnt == CW'(HDR - 1)) begin
          wr_cmd  <= sh[AW-1];
          rd_cmd  <= ~sh[AW-1];
          rf_addr <= {sh[AW-2:0], mosi};
        end
        if (cnt == CW'(DSTART - 1) && rd_cmd)
          tx_load <= 1'b1;
        if (cnt == CW'(FW - 1) && wr_cmd) begin
          rf_we    <= 1'b1;
          rf_wdata <= {sh[DW-2:0], mosi};
        end
      end
    end
  end

  assign tx_shift_ok = cs_act && rd_cmd && (cnt >= CW'(DSTART)) && (cnt < CW'(FW));

  // R9
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst) rf_we |=> !rf_we);
  // R5
  we_sel_chk: assert property (@(posedge clk) disable iff (rst) rf_we |-> $past(cs_act));
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst) !cs_act |=> $stable(rf_addr));
  // R7
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(FW));
endmodule

// File: rtl/spi_regbus_tx.sv
module spi_regbus_tx #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          sck_fall,
  input  logic          load,
  input  logic          shift_ok,
  input  logic [DW-1:0] rdata,
  output logic          miso
);
  logic [DW-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      sr   <= '0;
      miso <= 1'b0;
    end else if (load) begin
      sr <= rdata;
    end else if (sck_fall && shift_ok) begin
      miso <= sr[DW-1];
      sr   <= {sr[DW-2:0], 1'b0};
    end
  end

  // R6
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst) !cs_act |=> !miso);
  // R4
  miso_edge_chk: assert property (@(posedge clk) disable iff (rst) (cs_act && !sck_fall) |=> $stable(miso));
endmodule

// File: rtl/spi_regbus_slave.sv
module spi_regbus_slave
  import spi_regbus_pkg::*;
#(
  parameter int AW = ADDR_W_DEF,
  parameter int DW = DATA_W_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata,
  output logic          rf_we,
  input  logic [DW-1:0] rf_rdata
);
  logic [2:0] pins_s;
  logic       cs_s, sck_s, mosi_s, sck_q;
  logic       cs_act, sck_rise, sck_fall;
  logic       tx_load, tx_shift_ok;

  spi_regbus_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({spi_cs_n, spi_sck, spi_mosi}),
    .dout(pins_s)
  );

  assign {cs_s, sck_s, mosi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck_s;
  end

  assign cs_act   = ~cs_s;
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  spi_regbus_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .sck_rise   (sck_rise),
    .mosi       (mosi_s),
    .rf_addr    (rf_addr),
    .rf_wdata   (rf_wdata),
    .rf_we      (rf_we),
    .tx_load    (tx_load),
    .tx_shift_ok(tx_shift_ok)
  );

  spi_regbus_tx #(.DW(DW)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .cs_act  (cs_act),
    .sck_fall(sck_fall),
    .load    (tx_load),
    .shift_ok(tx_shift_ok),
    .rdata   (rf_rdata),
    .miso    (spi_miso)
  );
endmodule

// File: tb/spi_regbus_slave_bench.sv
module spi_regbus_slave_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_cs_n = 1'b1;
  logic        spi_sck = 1'b0;
  logic        spi_mosi = 1'b0;
  logic        spi_miso;
  logic [5:0]  rf_addr;
  logic [23:0] rf_wdata;
  logic        rf_we;
  logic [23:0] rf_rdata;

  logic [23:0] bmem    [64];
  logic [23:0] exp_mem [64];
  logic [29:0] wq [$];
  int n_chk = 0;
  int n_bad = 0;
  int idle_cnt = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_regbus_slave u_spi_regbus_slave (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata)
  );

  assign rf_rdata = bmem[rf_addr];

  initial begin
    for (int i = 0; i < 64; i++) begin
      bmem[i]    = 24'(i) * 24'h010101;
      exp_mem[i] = 24'(i) * 24'h010101;
    end
  end

  always @(posedge clk) if (!rst && rf_we) bmem[rf_addr] <= rf_wdata;

  // per-clock model comparison
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (spi_cs_n) idle_cnt++; else idle_cnt = 0;
      if (idle_cnt >= 5) begin
        n_chk++;
        if (spi_miso !== 1'b0) begin
          n_bad++;
          $display("FAIL R6 idle miso act=%b exp=0", spi_miso);
        end
      end
      if (rf_we === 1'b1) begin
        n_chk++;
        if (wq.size() == 0) begin
          n_bad++;
          $display("FAIL R9 unexpected strobe act=%h:%h exp=none", rf_addr, rf_wdata);
        end else begin
          if ({rf_addr, rf_wdata} !== wq[0]) begin
            n_bad++;
            $display("FAIL R2 write act=%h:%h exp=%h:%h", rf_addr, rf_wdata,
                     wq[0][29:24], wq[0][23:0]);
          end
          void'(wq.pop_front());
        end
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input bit wr, input logic [5:0] a, input logic [23:0] d,
                       input bit nul, input int nbits, output logic [31:0] cap);
    logic [31:0] f;
    f = {wr, a, nul, d};
    cap = '0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 32) ? f[31-i] : 1'b1;
      repeat (8) @(negedge clk);
      spi_sck = 1'b1;
      if (i < 32) cap[31-i] = spi_miso;
      repeat (8) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [23:0] d, input bit nul,
                          input int nbits, input string tag);
    logic [31:0] cap;
    if (nbits >= 32) begin
      wq.push_back({a, d});
      exp_mem[a] = d;
    end
    frame(1'b1, a, d, nul, nbits, cap);
    check({tag, " strobe seen"}, 32'(wq.size()), 32'd0);
    check("R6 miso low in write", cap, 32'd0);
  endtask

  task automatic do_read(input logic [5:0] a, input string tag);
    logic [31:0] cap;
    frame(1'b0, a, 24'h0, 1'b0, 32, cap);
    check({tag, " read data"}, {8'h0, cap[23:0]}, {8'h0, exp_mem[a]});
    check("R8 addr held", 32'(rf_addr), 32'(a));
  endtask

  initial begin
    logic [31:0] cap;
    repeat (4) @(negedge clk);
    // R1
    check("R1 we", 32'(rf_we), 0);
    check("R1 miso", 32'(spi_miso), 0);
    check("R1 addr", 32'(rf_addr), 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);

    do_write(6'd5, 24'hA5A5A5, 1'b0, 32, "R2");
    do_read(6'd5, "R4");
    do_read(6'd7, "R4");
    // R3: null bit set
    do_write(6'd63, 24'hFFFFFF, 1'b1, 32, "R3");
    do_read(6'd63, "R3");
    do_write(6'd0, 24'h123456, 1'b0, 32, "R2");
    do_read(6'd0, "R4");
    // R5: aborted writes
    do_write(6'd9, 24'h00BEEF, 1'b0, 31, "R5");
    do_write(6'd9, 24'h00BEEF, 1'b0, 10, "R5");
    do_read(6'd9, "R5");
    // R7: over-length write
    do_write(6'd10, 24'h0F0F0F, 1'b0, 40, "R7");
    do_read(6'd10, "R7");
    // aborted read then full read
    frame(1'b0, 6'd33, 24'h0, 1'b0, 15, cap);
    do_read(6'd33, "R4");
    do_write(6'd33, 24'h800001, 1'b0, 32, "R9");
    do_read(6'd33, "R4");

    repeat (20) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule